// File: doc/BRIEF.md
# Branch Resolve and Squash Controller

This controller steers a five-stage pipeline around conditional and linking branches. It watches the instruction entering decode and keeps its own record of any branch as it moves through decode, execute and memory access. In execute it forms the branch target and evaluates the zero test on the register A operand. In the memory stage it either redirects fetch to the target or lets sequential fetch go on. Every cycle it issues one command to each pipeline register: transfer, stall or bubble. The surrounding datapath applies these commands to its own registers.

A parameter picks one of two policies. In the freeze policy, fetch is held while a branch is in decode or execute, so the branch always costs two cycles and a taken branch costs one more. In the sequential-fetch policy, fetch never stops. When a branch resolves as taken, the three younger instructions are cancelled, and a branch that falls through costs nothing. A linking branch is always taken and returns its own incremented address for the register named in its ra field. A bubble clears every enable of the slot it hits, so a cancelled instruction changes no architectural state.

Top module: `branch_resolve_ctl`

## Requirements
- R1: A fetched word is decoded as opcode in bits [31:26], register index ra in [25:21] and a signed 21-bit displacement in [20:0]. The defaults are 0x39 for branch-if-zero, 0x3D for branch-if-nonzero and 0x34 for branch-and-link, and every other opcode is a non-branch. While an instruction is in decode, `id_ra_idx` carries its ra bits.
- R2: The target is the branch's incremented PC plus the sign-extended displacement shifted left by two. It is formed in execute and applied while the branch is in memory access.
- R3: Branch-if-zero is taken when the register A value is zero. Branch-if-nonzero is taken when it is not zero. Branch-and-link is always taken.
- R4: While a taken branch is in memory access, `br_taken` is 1 and `next_pc` is the target. Otherwise `next_pc` is `fetch_pc`+4, or `fetch_pc` itself when the fetch command is stall.
- R5: The commands are encoded as 2'b00 transfer, 2'b01 stall and 2'b10 bubble. 2'b11 never appears.
- R6: Freeze policy: while a branch is in decode or execute, the fetch command is stall and the decode command is bubble. Execute and memory get transfer.
- R7: Freeze policy: a taken branch in memory access gives fetch a transfer and decode a bubble. A taken branch costs three lost cycles and a fall-through branch costs two.
- R8: Sequential-fetch policy: a taken branch in memory access gives bubble to decode, execute and memory, and transfer to fetch. This squashes three younger instructions.
- R9: Sequential-fetch policy: with no taken branch in memory access, all four commands are transfer.
- R10: While a branch-and-link is in memory access, `link_we` is 1, `link_idx` is its ra and `link_data` is its incremented PC.
- R11: A branch that has been bubbled out later produces neither a redirect nor a link write. No taken cycle follows directly after another.
- R12: During and right after reset, no branch is tracked, all commands are transfer, and `br_taken` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | The fetched word is a real instruction |
| fetch_pc | input | AW | Address of the word being fetched |
| fetch_instr | input | 32 | Fetched instruction word |
| id_ra_idx | output | 5 | ra field of the instruction in decode, sent to the register file |
| id_ra_data | input | DW | Register value read for `id_ra_idx` |
| next_pc | output | AW | Fetch address for the next cycle |
| br_taken | output | 1 | A taken branch is redirecting fetch this cycle |
| cmd_if | output | 2 | Command for the PC register |
| cmd_id | output | 2 | Command for the fetch/decode register |
| cmd_ex | output | 2 | Command for the decode/execute register |
| cmd_mem | output | 2 | Command for the execute/memory register |
| link_we | output | 1 | Write enable for the link result |
| link_idx | output | 5 | Destination register of the link result |
| link_data | output | AW | Return address written by the link |

## Verification
Two events can fall in the same cycle: a taken branch redirecting from memory access, and a younger branch waiting in decode or execute. The bench provokes this with a taken branch followed directly by a branch-and-link and another branch-if-zero. It then confirms on the ports that the redirect wins the commands for that cycle, and that neither younger branch ever produces a second redirect or a link write. The same program also runs under the freeze policy, where the younger branch is bubbled as it enters decode instead of being cancelled later.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;

  // Per-register pipeline command
  typedef enum logic [1:0] {
    CMD_XFER   = 2'b00,
    CMD_STALL  = 2'b01,
    CMD_BUBBLE = 2'b10
  } stage_cmd_e;

  // Branch flavour carried down the pipe
  typedef enum logic [1:0] {
    BK_EQZ  = 2'd0,
    BK_NEZ  = 2'd1,
    BK_LINK = 2'd2
  } br_kind_e;

  localparam int POL_FREEZE = 0;
  localparam int POL_SEQ    = 1;

  localparam int INSTR_W = 32;
  localparam int DISP_W  = 21;
  localparam int REG_W   = 5;

endpackage

// File: rtl/brc_decode.sv
`timescale 1ns/1ps
module brc_decode
  import brc_pkg::*;
#(
  parameter logic [5:0] OPC_EQZ  = 6'h39,
  parameter logic [5:0] OPC_NEZ  = 6'h3D,
  parameter logic [5:0] OPC_LINK = 6'h34
) (
  input  logic                  valid,
  input  logic [INSTR_W-1:0]    instr,
  output logic                  is_br,
  output br_kind_e              kind,
  output logic [REG_W-1:0]      ra,
  output logic [DISP_W-1:0]     disp
);

  logic [5:0] opc;

  assign opc  = instr[31:26];
  assign ra   = instr[25:21];
  assign disp = instr[DISP_W-1:0];

  always_comb begin
    is_br = 1'b0;
    kind  = BK_EQZ;
    if (valid) begin
      if (opc == OPC_EQZ) begin
        is_br = 1'b1;
        kind  = BK_EQZ;
      end else if (opc == OPC_NEZ) begin
        is_br = 1'b1;
        kind  = BK_NEZ;
      end else if (opc == OPC_LINK) begin
        is_br = 1'b1;
        kind  = BK_LINK;
      end
    end
  end

endmodule

// File: rtl/brc_resolve.sv
`timescale 1ns/1ps
module brc_resolve
  import brc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  br_kind_e            kind,
  input  logic [AW-1:0]       pc_inc,
  input  logic [DISP_W-1:0]   disp,
  input  logic [DW-1:0]       ra_val,
  output logic [AW-1:0]       target,
  output logic                take
);

  localparam int SEXT_W = AW - DISP_W - 2;

  // Word displacement scaled to bytes, sign carried into the upper bits
  function automatic logic [AW-1:0] target_of(input logic [AW-1:0] inc,
                                              input logic [DISP_W-1:0] d);
    return inc + {{SEXT_W{d[DISP_W-1]}}, d, 2'b00};
  endfunction

  function automatic logic cond_of(input br_kind_e k, input logic [DW-1:0] v);
    logic z;
    z = (v == '0);
    case (k)
      BK_EQZ:  return z;
      BK_NEZ:  return !z;
      default: return 1'b1;
    endcase
  endfunction

  assign target = target_of(pc_inc, disp);
  assign take   = cond_of(kind, ra_val);

endmodule

// File: rtl/brc_cmd_gen.sv
`timescale 1ns/1ps
module brc_cmd_gen
  import brc_pkg::*;
#(
  parameter int POLICY = POL_SEQ
) (
  input  logic        id_br,
  input  logic        ex_br,
  input  logic        mem_redirect,
  output stage_cmd_e  c_if,
  output stage_cmd_e  c_id,
  output stage_cmd_e  c_ex,
  output stage_cmd_e  c_mem
);

  generate
    if (POLICY == POL_FREEZE) begin : g_freeze
      always_comb begin
        c_if  = CMD_XFER;
        c_id  = CMD_XFER;
        c_ex  = CMD_XFER;
        c_mem = CMD_XFER;
        if (mem_redirect) begin
          c_id = CMD_BUBBLE;
        end else if (id_br || ex_br) begin
          c_if = CMD_STALL;
          c_id = CMD_BUBBLE;
        end
      end
    end else begin : g_seq
      logic unused_pending;
      assign unused_pending = id_br ^ ex_br;
      always_comb begin
        c_if  = CMD_XFER;
        c_id  = CMD_XFER;
        c_ex  = CMD_XFER;
        c_mem = CMD_XFER;
        if (mem_redirect) begin
          c_id  = CMD_BUBBLE;
          c_ex  = CMD_BUBBLE;
          c_mem = CMD_BUBBLE;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/branch_resolve_ctl.sv
`timescale 1ns/1ps
module branch_resolve_ctl
  import brc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 64,
  parameter int          POLICY   = POL_SEQ,
  parameter logic [5:0]  OPC_EQZ  = 6'h39,
  parameter logic [5:0]  OPC_NEZ  = 6'h3D,
  parameter logic [5:0]  OPC_LINK = 6'h34
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [AW-1:0]       fetch_pc,
  input  logic [31:0]         fetch_instr,
  output logic [4:0]          id_ra_idx,
  input  logic [DW-1:0]       id_ra_data,
  output logic [AW-1:0]       next_pc,
  output logic                br_taken,
  output logic [1:0]          cmd_if,
  output logic [1:0]          cmd_id,
  output logic [1:0]          cmd_ex,
  output logic [1:0]          cmd_mem,
  output logic                link_we,
  output logic [4:0]          link_idx,
  output logic [AW-1:0]       link_data
);

  localparam logic [AW-1:0] STEP = AW'(4);

  function automatic logic [AW-1:0] incr(input logic [AW-1:0] pc);
    return pc + STEP;
  endfunction

  // Decode-stage copy
  logic                 id_vld;
  logic [INSTR_W-1:0]   id_instr;
  logic [AW-1:0]        id_inc;

  // Execute-stage branch record
  logic                 ex_busy;
  br_kind_e             ex_kind;
  logic [AW-1:0]        ex_inc;
  logic [DISP_W-1:0]    ex_disp;
  logic [REG_W-1:0]     ex_ra;
  logic [DW-1:0]        ex_val;

  // Memory-stage branch record
  logic                 mem_busy;
  br_kind_e             mem_kind;
  logic                 mem_take;
  logic [AW-1:0]        mem_tgt;
  logic [AW-1:0]        mem_inc;
  logic [REG_W-1:0]     mem_ra;

  // Named events
  logic                 id_is_br;
  br_kind_e             id_kind;
  logic [REG_W-1:0]     id_ra;
  logic [DISP_W-1:0]    id_disp;
  logic [AW-1:0]        ex_tgt;
  logic                 ex_take;
  logic                 redirect;
  logic [AW-1:0]        fetch_inc;
  stage_cmd_e           c_if, c_id, c_ex, c_mem;

  assign fetch_inc = incr(fetch_pc);

  brc_decode #(
    .OPC_EQZ  (OPC_EQZ),
    .OPC_NEZ  (OPC_NEZ),
    .OPC_LINK (OPC_LINK)
  ) u_decode (
    .valid (id_vld),
    .instr (id_instr),
    .is_br (id_is_br),
    .kind  (id_kind),
    .ra    (id_ra),
    .disp  (id_disp)
  );

  brc_resolve #(.AW(AW), .DW(DW)) u_resolve (
    .kind   (ex_kind),
    .pc_inc (ex_inc),
    .disp   (ex_disp),
    .ra_val (ex_val),
    .target (ex_tgt),
    .take   (ex_take)
  );

  assign redirect = mem_busy && mem_take;

  brc_cmd_gen #(.POLICY(POLICY)) u_cmd (
    .id_br        (id_is_br),
    .ex_br        (ex_busy),
    .mem_redirect (redirect),
    .c_if         (c_if),
    .c_id         (c_id),
    .c_ex         (c_ex),
    .c_mem        (c_mem)
  );

  // Fetch -> decode register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_vld   <= 1'b0;
      id_instr <= '0;
      id_inc   <= '0;
    end else begin
      case (c_id)
        CMD_XFER: begin
          id_vld   <= fetch_valid;
          id_instr <= fetch_instr;
          id_inc   <= fetch_inc;
        end
        CMD_BUBBLE: id_vld <= 1'b0;
        default: ;
      endcase
    end
  end

  // Decode -> execute register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_busy <= 1'b0;
      ex_kind <= BK_EQZ;
      ex_inc  <= '0;
      ex_disp <= '0;
      ex_ra   <= '0;
      ex_val  <= '0;
    end else begin
      case (c_ex)
        CMD_XFER: begin
          ex_busy <= id_is_br;
          ex_kind <= id_kind;
          ex_inc  <= id_inc;
          ex_disp <= id_disp;
          ex_ra   <= id_ra;
          ex_val  <= id_ra_data;
        end
        CMD_BUBBLE: ex_busy <= 1'b0;
        default: ;
      endcase
    end
  end

  // Execute -> memory register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_busy <= 1'b0;
      mem_kind <= BK_EQZ;
      mem_take <= 1'b0;
      mem_tgt  <= '0;
      mem_inc  <= '0;
      mem_ra   <= '0;
    end else begin
      case (c_mem)
        CMD_XFER: begin
          mem_busy <= ex_busy;
          mem_kind <= ex_kind;
          mem_take <= ex_take;
          mem_tgt  <= ex_tgt;
          mem_inc  <= ex_inc;
          mem_ra   <= ex_ra;
        end
        CMD_BUBBLE: mem_busy <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (redirect)              next_pc = mem_tgt;
    else if (c_if == CMD_STALL) next_pc = fetch_pc;
    else                       next_pc = fetch_inc;
  end

  assign id_ra_idx = id_ra;
  assign br_taken  = redirect;
  assign cmd_if    = c_if;
  assign cmd_id    = c_id;
  assign cmd_ex    = c_ex;
  assign cmd_mem   = c_mem;
  assign link_we   = mem_busy && (mem_kind == BK_LINK);
  assign link_idx  = mem_ra;
  assign link_data = mem_inc;

endmodule

// File: rtl/brc_checker.sv
`timescale 1ns/1ps
module brc_checker #(
  parameter int AW     = 32,
  parameter int POLICY = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_taken,
  input logic          link_we,
  input logic [1:0]    cmd_if,
  input logic [1:0]    cmd_id,
  input logic [1:0]    cmd_ex,
  input logic [1:0]    cmd_mem,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] fetch_pc,
  input logic          id_is_br,
  input logic          ex_busy
);

  localparam bit FREEZE = (POLICY == 0);

  assert_cmd_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_if != 2'b11) && (cmd_id != 2'b11) && (cmd_ex != 2'b11) && (cmd_mem != 2'b11));

  assert_hold_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_if == 2'b01) |-> (next_pc == fetch_pc && !br_taken));

  assert_freeze_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (FREEZE && (id_is_br || ex_busy)) |-> (cmd_if == 2'b01 && cmd_id == 2'b10
                                           && cmd_ex == 2'b00 && cmd_mem == 2'b00));

  assert_freeze_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (FREEZE && br_taken) |-> (cmd_if == 2'b00 && cmd_id == 2'b10));

  assert_squash_three_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!FREEZE && br_taken) |-> (cmd_if == 2'b00 && cmd_id == 2'b10
                               && cmd_ex == 2'b10 && cmd_mem == 2'b10));

  assert_seq_flow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!FREEZE && !br_taken) |-> (cmd_if == 2'b00 && cmd_id == 2'b00
                                && cmd_ex == 2'b00 && cmd_mem == 2'b00));

  assert_link_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> br_taken);

  assert_no_second_R11: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (!br_taken && !link_we));

endmodule

bind branch_resolve_ctl brc_checker #(.AW(AW), .POLICY(POLICY)) u_brc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .br_taken (br_taken),
  .link_we  (link_we),
  .cmd_if   (cmd_if),
  .cmd_id   (cmd_id),
  .cmd_ex   (cmd_ex),
  .cmd_mem  (cmd_mem),
  .next_pc  (next_pc),
  .fetch_pc (fetch_pc),
  .id_is_br (id_is_br),
  .ex_busy  (ex_busy)
);

// File: tb/branch_resolve_ctl_bench.sv
`timescale 1ns/1ps
module branch_resolve_ctl_bench;

  localparam int AW = 32;
  localparam int DW = 64;

  typedef struct {
    logic [7:0]  cm;
    logic [31:0] npc;
    logic        tk;
    logic        lw;
    logic [4:0]  li;
    logic [31:0] ld;
    string       rq;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        done = 1'b0;
  int          sc = 0;
  logic [31:0] start_pc = '0;
  int          checks = 0;
  int          errors = 0;
  exp_t        q_seq[$];
  exp_t        q_frz[$];

  // Environment helpers
  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] ra, input int d);
    logic [31:0] dv;
    dv = d;
    return {op, ra, dv[20:0]};
  endfunction

  function automatic logic [31:0] imem(input int s, input logic [31:0] a);
    logic [31:0] nop;
    nop = {6'h10, 26'h0};
    case (s)
      1: case (a)
           32'h00: return enc(6'h39, 5'd1, 5);
           32'h04: return enc(6'h34, 5'd3, 1);
           32'h08: return enc(6'h39, 5'd1, 0);
           default: return nop;
         endcase
      2: case (a)
           32'h00: return enc(6'h3D, 5'd1, 5);
           32'h04: return enc(6'h3D, 5'd1, 5);
           default: return nop;
         endcase
      3: return (a == 32'h00) ? enc(6'h34, 5'd3, 3) : nop;
      4: return (a == 32'h40) ? enc(6'h3D, 5'd2, -8) : nop;
      5: return (a == 32'h00) ? enc(6'h39, 5'd2, 5) : nop;
      default: return nop;
    endcase
  endfunction

  function automatic logic [DW-1:0] rfv(input logic [4:0] i);
    case (i)
      5'd1, 5'd31: return '0;
      5'd2:        return 64'd7;
      default:     return DW'(i) + 64'd100;
    endcase
  endfunction

  // Sequential-fetch instance
  logic [31:0] pc_p, np_p, ld_p;
  logic [4:0]  ri_p, li_p;
  logic [1:0]  cif_p, cid_p, cex_p, cmm_p;
  logic        tk_p, lw_p;

  branch_resolve_ctl #(.AW(AW), .DW(DW), .POLICY(1)) u_branch_resolve_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(1'b1), .fetch_pc(pc_p),
    .fetch_instr(imem(sc, pc_p)), .id_ra_idx(ri_p), .id_ra_data(rfv(ri_p)),
    .next_pc(np_p), .br_taken(tk_p), .cmd_if(cif_p), .cmd_id(cid_p),
    .cmd_ex(cex_p), .cmd_mem(cmm_p), .link_we(lw_p), .link_idx(li_p), .link_data(ld_p)
  );

  // Freeze instance
  logic [31:0] pc_s, np_s, ld_s;
  logic [4:0]  ri_s, li_s;
  logic [1:0]  cif_s, cid_s, cex_s, cmm_s;
  logic        tk_s, lw_s;

  branch_resolve_ctl #(.AW(AW), .DW(DW), .POLICY(0)) u_branch_resolve_ctl_frz (
    .clk(clk), .rst_n(rst_n), .fetch_valid(1'b1), .fetch_pc(pc_s),
    .fetch_instr(imem(sc, pc_s)), .id_ra_idx(ri_s), .id_ra_data(rfv(ri_s)),
    .next_pc(np_s), .br_taken(tk_s), .cmd_if(cif_s), .cmd_id(cid_s),
    .cmd_ex(cex_s), .cmd_mem(cmm_s), .link_we(lw_s), .link_idx(li_s), .link_data(ld_s)
  );

  // PC registers of the fetch environment
  always @(posedge clk) begin
    pc_p <= rst_n ? np_p : start_pc;
    pc_s <= rst_n ? np_s : start_pc;
  end

  task automatic chk(input bit ok, input string what, input string rq,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h (scenario %0d)", rq, what, act, expv, sc);
    end
  endtask

  task automatic cmp(input string tag, input exp_t e, input logic [7:0] cm,
                     input logic [31:0] np, input logic tk, input logic lw,
                     input logic [4:0] li, input logic [31:0] ld);
    chk(cm === e.cm, {tag, " cmds"}, e.rq, 32'(cm), 32'(e.cm));
    chk(np === e.npc, {tag, " next_pc"}, e.rq, np, e.npc);
    chk(tk === e.tk, {tag, " taken"}, e.rq, 32'(tk), 32'(e.tk));
    chk(lw === e.lw, {tag, " link_we"}, e.rq, 32'(lw), 32'(e.lw));
    if (e.lw) begin
      chk(li === e.li, {tag, " link_idx"}, "R10", 32'(li), 32'(e.li));
      chk(ld === e.ld, {tag, " link_data"}, "R10", ld, e.ld);
    end
  endtask

  // Monitor: pop one expected item per policy each sampled cycle
  always @(negedge clk) begin
    if (run) begin
      if (q_seq.size() == 0) chk(1'b0, "seq scoreboard underflow", "R9", 0, 0);
      else cmp("seq", q_seq.pop_front(), {cif_p, cid_p, cex_p, cmm_p}, np_p, tk_p, lw_p, li_p, ld_p);
      if (q_frz.size() == 0) chk(1'b0, "frz scoreboard underflow", "R6", 0, 0);
      else cmp("frz", q_frz.pop_front(), {cif_s, cid_s, cex_s, cmm_s}, np_s, tk_s, lw_s, li_s, ld_s);
    end
  end

  // Driver: push expected item
  task automatic ex(input bit frz, input logic [7:0] cm, input logic [31:0] np,
                    input bit tk, input bit lw, input logic [4:0] li,
                    input logic [31:0] ld, input string rq);
    exp_t e;
    e.cm = cm; e.npc = np; e.tk = tk; e.lw = lw; e.li = li; e.ld = ld; e.rq = rq;
    if (frz) q_frz.push_back(e);
    else     q_seq.push_back(e);
  endtask

  task automatic run_sc(input int s, input logic [31:0] st, input int n);
    sc = s;
    start_pc = st;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state on both policies
    chk({cif_p, cid_p, cex_p, cmm_p, tk_p, lw_p} === 10'b0, "seq reset outputs", "R12",
        32'({cif_p, cid_p, cex_p, cmm_p, tk_p, lw_p}), 0);
    chk({cif_s, cid_s, cex_s, cmm_s, tk_s, lw_s} === 10'b0, "frz reset outputs", "R12",
        32'({cif_s, cid_s, cex_s, cmm_s, tk_s, lw_s}), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (n) @(negedge clk);
    #1 run = 1'b0;
    chk(q_seq.size() == 0, "seq items left", "R9", q_seq.size(), 0);
    chk(q_frz.size() == 0, "frz items left", "R6", q_frz.size(), 0);
  endtask

  initial begin
    // S1: taken zero-branch, then link and zero-branch behind it (R11 overlap)
    ex(0, 8'h00, 32'h04, 0, 0, 0, 0, "R9");
    ex(0, 8'h00, 32'h08, 0, 0, 0, 0, "R9");
    ex(0, 8'h00, 32'h0c, 0, 0, 0, 0, "R9");
    ex(0, 8'h2A, 32'h18, 1, 0, 0, 0, "R8");
    ex(0, 8'h00, 32'h1c, 0, 0, 0, 0, "R11");
    ex(0, 8'h00, 32'h20, 0, 0, 0, 0, "R11");
    ex(1, 8'h00, 32'h04, 0, 0, 0, 0, "R12");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h20, 32'h18, 1, 0, 0, 0, "R7");
    ex(1, 8'h00, 32'h1c, 0, 0, 0, 0, "R11");
    ex(1, 8'h00, 32'h20, 0, 0, 0, 0, "R11");
    run_sc(1, 32'h0, 6);

    // S2: two back-to-back nonzero-branches that fall through
    for (int i = 0; i < 7; i++) ex(0, 8'h00, 32'(4 * (i + 1)), 0, 0, 0, 0, "R9");
    ex(1, 8'h00, 32'h04, 0, 0, 0, 0, "R3");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h00, 32'h08, 0, 0, 0, 0, "R7");
    ex(1, 8'h60, 32'h08, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h08, 0, 0, 0, 0, "R6");
    ex(1, 8'h00, 32'h0c, 0, 0, 0, 0, "R7");
    run_sc(2, 32'h0, 7);

    // S3: branch-and-link, always taken, writes return address
    ex(0, 8'h00, 32'h04, 0, 0, 0, 0, "R1");
    ex(0, 8'h00, 32'h08, 0, 0, 0, 0, "R1");
    ex(0, 8'h00, 32'h0c, 0, 0, 0, 0, "R1");
    ex(0, 8'h2A, 32'h10, 1, 1, 5'd3, 32'h04, "R10");
    ex(0, 8'h00, 32'h14, 0, 0, 0, 0, "R4");
    ex(1, 8'h00, 32'h04, 0, 0, 0, 0, "R1");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h20, 32'h10, 1, 1, 5'd3, 32'h04, "R10");
    ex(1, 8'h00, 32'h14, 0, 0, 0, 0, "R4");
    run_sc(3, 32'h0, 5);

    // S4: nonzero-branch taken with a negative displacement
    ex(0, 8'h00, 32'h44, 0, 0, 0, 0, "R4");
    ex(0, 8'h00, 32'h48, 0, 0, 0, 0, "R4");
    ex(0, 8'h00, 32'h4c, 0, 0, 0, 0, "R4");
    ex(0, 8'h2A, 32'h24, 1, 0, 0, 0, "R2");
    ex(0, 8'h00, 32'h28, 0, 0, 0, 0, "R4");
    ex(1, 8'h00, 32'h44, 0, 0, 0, 0, "R4");
    ex(1, 8'h60, 32'h44, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h44, 0, 0, 0, 0, "R6");
    ex(1, 8'h20, 32'h24, 1, 0, 0, 0, "R2");
    ex(1, 8'h00, 32'h28, 0, 0, 0, 0, "R4");
    run_sc(4, 32'h40, 5);

    // S5: zero-branch on a nonzero register falls through
    ex(0, 8'h00, 32'h04, 0, 0, 0, 0, "R3");
    ex(0, 8'h00, 32'h08, 0, 0, 0, 0, "R3");
    ex(0, 8'h00, 32'h0c, 0, 0, 0, 0, "R3");
    ex(0, 8'h00, 32'h10, 0, 0, 0, 0, "R3");
    ex(1, 8'h00, 32'h04, 0, 0, 0, 0, "R3");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h60, 32'h04, 0, 0, 0, 0, "R6");
    ex(1, 8'h00, 32'h08, 0, 0, 0, 0, "R3");
    run_sc(5, 32'h0, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired in scenario %0d", sc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule